// File: doc/BRIEF.md
# Manchester Line Transmitter with Busy-Window Collision Guard

This block turns a serial stream of message bits into a two-level Manchester waveform for a radio data link, and watches the link while it transmits. The bit source offers one bit whenever the block raises its bit request. Each bit goes out as two half-bit levels of equal length. A rate select picks one of two half-bit lengths, given in system clock cycles, to suit a 10 kHz or an 8 kHz bit clock. An invert control flips the polarity of the line.

While a message goes out, the block expects the far end to show activity on a busy input. It looks only within a window of bit positions. If busy is never seen in that window, the block stops the message at once and sets a sticky collision flag. It pulses an interrupt and refuses new messages until a transmit-path reset. A transmit-key output is high for the length of a message. On a collision it either releases the transmitter or leaves it keyed, as a control input selects.

Top module: `manch_tx_guard`

## Requirements
- R1: After reset, manch_out, bit_req, collision, irq and tx_key are all 0.
- R2: A bit value 1 is sent as high for one half-bit and then low for one half-bit, and 0 as low then high (before inversion). bit_in is sampled in every cycle in which bit_req is high. The first bit of a message is requested in the same cycle as an accepted msg_go, and its first half starts on the next cycle.
- R3: A half-bit lasts HALF_DIV_FAST clock cycles when rate_sel is 0 and HALF_DIV_SLOW cycles when rate_sel is 1. The value is taken at message start.
- R4: invert=1 flips both half-bit levels. While no message is being sent, manch_out is 0 whatever invert is.
- R5: A message is MSG_BITS bits long. bit_req is high for exactly one cycle per bit: for bit 0 with msg_go, and for each later bit in the final cycle of the previous bit. When the message ends, the line returns to idle.
- R6: If busy is high in at least one cycle while a bit with 0-based index WIN_LO through WIN_HI-1 is being sent, no collision occurs and the message completes.
- R7: If busy is not seen in that window, collision rises on the cycle after the last cycle of bit WIN_HI-1. From that cycle the message is dropped: manch_out is 0 and bit_req stays low. Busy before or after the window does not count.
- R8: collision stays high until tx_rst is asserted. While collision is set, msg_go is ignored. tx_rst clears collision and tx_key on the next cycle.
- R9: irq is high for exactly one cycle, namely the first cycle in which collision is high.
- R10: tx_key is high from the cycle after msg_go is accepted until the message ends. On a collision, tx_key goes low when txctl_en is 1. When txctl_en is 0 it stays high until tx_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_go | input | 1 | Start a message (accepted when idle and no collision) |
| bit_in | input | 1 | Next message bit, sampled while bit_req is high |
| rate_sel | input | 1 | 0: fast half-bit length, 1: slow half-bit length |
| invert | input | 1 | Flip line polarity |
| busy | input | 1 | Busy indication from the far end |
| txctl_en | input | 1 | Release the transmitter key on collision |
| tx_rst | input | 1 | Transmit-path reset: aborts, clears collision and key |
| bit_req | output | 1 | Request for the next message bit |
| manch_out | output | 1 | Manchester line output |
| collision | output | 1 | Sticky collision flag |
| irq | output | 1 | One-cycle collision interrupt |
| tx_key | output | 1 | Transmitter key |

## Verification
Suppose the half-bit counter holds a wrong limit or the half flag is wrong. Then manch_out leaves the expected waveform within one half-bit, and each following bit request falls on the wrong cycle. If the bit index is wrong, a collision comes one bit early or late, or bit requests keep coming past the last bit. A busy-seen flag that is not cleared or not set shows up by the end of bit WIN_HI-1, as collision and irq either missing or present when they should not be. A lost sticky flag or a lost key state shows at the next attempted msg_go or before tx_rst.

// File: rtl/mtx_pkg.sv
// Shared types for the Manchester transmitter.
// Assumes: nothing beyond a single clock domain.
package mtx_pkg;
    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;
endpackage

// File: rtl/mtx_tick_gen.sv
// Half-bit tick divider. It produces one tick at the end of every half-bit
// while the line runs. The half-bit length is latched when a message starts.
// Assumes: load only arrives while run is low.
module mtx_tick_gen
    import mtx_pkg::*;
#(
    parameter int DIV_FAST = 6250,
    parameter int DIV_SLOW = 7812
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rate_sel,
    input  logic run,
    output logic tick
);
    localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_q;

    assign tick = run && (cnt == lim_q);

    // latch the rate at message start and count cycles within a half-bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            lim_q <= CW'(DIV_FAST - 1);
        end else if (load) begin
            cnt   <= '0;
            lim_q <= (rate_e'(rate_sel) == RATE_SLOW) ? CW'(DIV_SLOW - 1)
                                                      : CW'(DIV_FAST - 1);
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim_q)); // R3
endmodule

// File: rtl/mtx_line_coder.sv
// Manchester line coder. It holds the current bit, the half-bit phase and the
// bit index, requests each bit from the source and drives the line level.
// Assumes: start arrives only while idle. abort overrides start.
module mtx_line_coder #(
    parameter int MSG_BITS = 240,
    parameter int IW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic          tick,
    input  logic          bit_in,
    input  logic          invert,
    output logic          active,
    output logic          bit_req,
    output logic          bit_end,
    output logic          msg_done,
    output logic [IW-1:0] bit_idx,
    output logic          line
);
    logic cur;
    logic half;
    logic last;

    assign last     = (bit_idx == IW'(MSG_BITS - 1));
    assign bit_end  = active && tick && half;
    assign msg_done = bit_end && last && !abort;
    assign bit_req  = start || (bit_end && !last && !abort);
    assign line     = active && (cur ^ half ^ invert);

    // step through halves and bits, loading each new bit on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            half    <= 1'b0;
            cur     <= 1'b0;
            bit_idx <= '0;
        end else if (abort) begin
            active  <= 1'b0;
            half    <= 1'b0;
            bit_idx <= '0;
        end else if (start) begin
            active  <= 1'b1;
            half    <= 1'b0;
            cur     <= bit_in;
            bit_idx <= '0;
        end else if (active && tick) begin
            if (!half) begin
                half <= 1'b1;
            end else if (last) begin
                active  <= 1'b0;
                half    <= 1'b0;
                bit_idx <= '0;
            end else begin
                half    <= 1'b0;
                cur     <= bit_in;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    AST_REQ_LEADS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> active); // R5
    AST_HALF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !abort && !start) |=> $stable(half)); // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_idx <= IW'(MSG_BITS - 1))); // R5
endmodule

// File: rtl/mtx_busy_watch.sv
// Busy-window collision monitor. It records whether busy was seen during the
// window of bit positions and declares a sticky collision at the window's end.
// Assumes: bit_idx and bit_end come from the line coder of the same message.
module mtx_busy_watch #(
    parameter int WIN_LO = 56,
    parameter int WIN_HI = 104,
    parameter int IW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start,
    input  logic          active,
    input  logic          bit_end,
    input  logic [IW-1:0] bit_idx,
    input  logic          busy,
    output logic          coll_set,
    output logic          collision,
    output logic          irq
);
    logic seen;
    logic in_win;
    logic seen_now;

    assign in_win   = active && (bit_idx >= IW'(WIN_LO)) && (bit_idx < IW'(WIN_HI));
    assign seen_now = seen || (busy && in_win);
    assign coll_set = bit_end && (bit_idx == IW'(WIN_HI - 1)) && !seen_now
                      && !collision && !clr;

    // remember busy within the window for the current message
    always_ff @(posedge clk) begin
        if (!rst_n || start || clr) begin
            seen <= 1'b0;
        end else if (busy && in_win) begin
            seen <= 1'b1;
        end
    end

    // sticky collision flag and its one-cycle interrupt
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            collision <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (coll_set) collision <= 1'b1;
            irq <= coll_set;
        end
    end

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && !clr) |=> collision); // R8
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_IRQ_WITH_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> collision); // R9
endmodule

// File: rtl/manch_tx_guard.sv
// Top of the Manchester transmitter with busy-window collision guard.
// It ties together the divider, the line coder and the busy monitor, and
// owns the transmitter key.
// Assumes: rate_sel and invert are steady during a message. WIN_LO < WIN_HI <= MSG_BITS.
module manch_tx_guard #(
    parameter int HALF_DIV_FAST = 6250,
    parameter int HALF_DIV_SLOW = 7812,
    parameter int MSG_BITS      = 240,
    parameter int WIN_LO        = 56,
    parameter int WIN_HI        = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic msg_go,
    input  logic bit_in,
    input  logic rate_sel,
    input  logic invert,
    input  logic busy,
    input  logic txctl_en,
    input  logic tx_rst,
    output logic bit_req,
    output logic manch_out,
    output logic collision,
    output logic irq,
    output logic tx_key
);
    localparam int IW = $clog2(MSG_BITS);

    generate
        if (WIN_HI > MSG_BITS || WIN_LO >= WIN_HI) begin : g_bad_window
            $error("busy window must lie inside the message");
        end
    endgenerate

    logic          active;
    logic          tick;
    logic          bit_end;
    logic          msg_done;
    logic [IW-1:0] bit_idx;
    logic          coll_set;
    logic          go_ok;
    logic          abort;

    assign go_ok = msg_go && !active && !collision && !tx_rst;
    assign abort = coll_set || tx_rst;

    mtx_tick_gen #(.DIV_FAST(HALF_DIV_FAST), .DIV_SLOW(HALF_DIV_SLOW)) u_tick (
        .clk(clk), .rst_n(rst_n), .load(go_ok), .rate_sel(rate_sel),
        .run(active), .tick(tick)
    );

    mtx_line_coder #(.MSG_BITS(MSG_BITS), .IW(IW)) u_coder (
        .clk(clk), .rst_n(rst_n), .start(go_ok), .abort(abort), .tick(tick),
        .bit_in(bit_in), .invert(invert), .active(active), .bit_req(bit_req),
        .bit_end(bit_end), .msg_done(msg_done), .bit_idx(bit_idx), .line(manch_out)
    );

    mtx_busy_watch #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .IW(IW)) u_watch (
        .clk(clk), .rst_n(rst_n), .clr(tx_rst), .start(go_ok), .active(active),
        .bit_end(bit_end), .bit_idx(bit_idx), .busy(busy), .coll_set(coll_set),
        .collision(collision), .irq(irq)
    );

    // key the transmitter for a message; on collision release it if enabled
    always_ff @(posedge clk) begin
        if (!rst_n || tx_rst) begin
            tx_key <= 1'b0;
        end else if (go_ok) begin
            tx_key <= 1'b1;
        end else if (coll_set) begin
            tx_key <= !txctl_en;
        end else if (msg_done) begin
            tx_key <= 1'b0;
        end
    end

    AST_DROP_ON_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (!bit_req && !manch_out)); // R7
    AST_KEY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(collision) && $past(txctl_en)) |-> !tx_key); // R10
    AST_KEY_COVERS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> tx_key); // R10
endmodule

// File: tb/tb_manch_tx_guard.sv
module tb_manch_tx_guard;
    localparam int F  = 3;
    localparam int S  = 4;
    localparam int N  = 24;
    localparam int LO = 8;
    localparam int HI = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_go = 1'b0, bit_in = 1'b0, rate_sel = 1'b0, invert = 1'b0;
    logic busy = 1'b0, txctl_en = 1'b0, tx_rst = 1'b0;
    logic bit_req, manch_out, collision, irq, tx_key;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    manch_tx_guard #(.HALF_DIV_FAST(F), .HALF_DIV_SLOW(S), .MSG_BITS(N),
                     .WIN_LO(LO), .WIN_HI(HI)) dut (
        .clk(clk), .rst_n(rst_n), .msg_go(msg_go), .bit_in(bit_in),
        .rate_sel(rate_sel), .invert(invert), .busy(busy), .txctl_en(txctl_en),
        .tx_rst(tx_rst), .bit_req(bit_req), .manch_out(manch_out),
        .collision(collision), .irq(irq), .tx_key(tx_key)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit expect_coll(input int busy_bit);
        return !(busy_bit >= LO && busy_bit < HI);
    endfunction

    function automatic logic line_level(input logic b, input int h, input logic inv);
        return b ^ (h == 1) ^ inv;
    endfunction

    task automatic run_msg(input logic [N-1:0] data, input logic rate, input logic inv,
                           input int busy_bit, input logic en);
        int  div;
        bit  seen;
        bit  coll;
        bit  last;
        bit  here;
        div  = rate ? S : F;
        seen = 1'b0;
        coll = 1'b0;
        @(negedge clk);
        rate_sel = rate; invert = inv; txctl_en = en; busy = 1'b0;
        msg_go = 1'b1; bit_in = data[0];
        #1;
        check("R5 first bit_req with msg_go", bit_req, 1'b1);
        check("R4 idle line low", manch_out, 1'b0);
        for (int b = 0; b < N && !coll; b++) begin
            for (int h = 0; h < 2 && !coll; h++) begin
                for (int k = 0; k < div && !coll; k++) begin
                    @(negedge clk);
                    msg_go = 1'b0;
                    busy = (b == busy_bit);
                    last = (h == 1) && (k == div - 1);
                    if (last && b < N - 1) bit_in = data[b+1];
                    #1;
                    check("R2 R3 R4 line level", manch_out, line_level(data[b], h, inv));
                    check("R10 key during message", tx_key, 1'b1);
                    if (busy && b >= LO && b < HI) seen = 1'b1;
                    here = last && (b == HI - 1) && !seen;
                    check("R5 bit_req timing", bit_req, last && (b < N - 1) && !here);
                    if (here) coll = 1'b1;
                end
            end
        end
        check("R6 R7 collision outcome", coll, expect_coll(busy_bit));
        @(negedge clk);
        busy = 1'b0;
        #1;
        if (coll) begin
            check("R7 collision raised", collision, 1'b1);
            check("R9 irq with collision", irq, 1'b1);
            check("R7 line dropped", manch_out, 1'b0);
            check("R7 no bit_req", bit_req, 1'b0);
            check("R10 key after collision", tx_key, !en);
            @(negedge clk); #1;
            check("R9 irq single cycle", irq, 1'b0);
            check("R8 collision held", collision, 1'b1);
            msg_go = 1'b1; bit_in = 1'b1; invert = 1'b0;
            #1;
            check("R8 msg_go ignored", bit_req, 1'b0);
            @(negedge clk); msg_go = 1'b0; #1;
            check("R8 no line after ignored go", manch_out, 1'b0);
            check("R8 collision still held", collision, 1'b1);
            tx_rst = 1'b1;
            @(negedge clk); tx_rst = 1'b0; #1;
            check("R8 collision cleared", collision, 1'b0);
            check("R8 key cleared", tx_key, 1'b0);
        end else begin
            check("R6 no collision", collision, 1'b0);
            check("R5 line idle after message", manch_out, 1'b0);
            check("R5 no extra bit_req", bit_req, 1'b0);
            check("R10 key released at end", tx_key, 1'b0);
            check("R6 no irq", irq, 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset manch_out", manch_out, 1'b0);
        check("R1 reset bit_req", bit_req, 1'b0);
        check("R1 reset collision", collision, 1'b0);
        check("R1 reset irq", irq, 1'b0);
        check("R1 reset tx_key", tx_key, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        // directed corners
        run_msg({N{1'b1}}, 1'b0, 1'b0, LO, 1'b1);
        run_msg({N{1'b0}}, 1'b1, 1'b1, HI - 1, 1'b0);
        run_msg(24'hA5C3F0, 1'b0, 1'b1, -1, 1'b1);
        run_msg(24'h0F1E2D, 1'b1, 1'b0, LO - 1, 1'b0);
        run_msg(24'h13579B, 1'b0, 1'b0, HI, 1'b1);
        run_msg(24'hFEDCBA, 1'b1, 1'b1, HI, 1'b0);
        // constrained random
        for (int i = 0; i < 24; i++) begin
            int bb;
            bb = int'($urandom_range(0, N));
            if (bb == N) bb = -1;
            run_msg(N'($urandom), 1'($urandom), 1'($urandom), bb, 1'($urandom));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule